// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host side of a link to a 12-bit serial analog-to-digital converter. Each frame reads one sample. A start request lowers the active-low chip-select. The block then makes a serial clock from the system clock and shifts in the converter's data line on every rising serial-clock edge. It removes the two zero pad bits that come before the result and presents the 12 result bits with a one-cycle valid strobe.

A mode input picks the frame length. A short frame has 14 serial clocks and releases chip-select on the clock that delivers the last result bit, which gives the highest sample rate. A long frame has 16 serial clocks and also reads two trailing pad bits.

After each frame, chip-select stays high for a programmable number of system cycles. This covers the converter's quiet and acquisition time. Pad bits that are not zero raise an error pulse. A start that arrives while a frame or quiet interval is running is remembered. It launches the next frame as soon as the interval ends.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `cs_n_o` and `sclk_o` are 1, and `valid_o`, `err_o` and `data_o` are 0.
- R2: From idle, a start request sampled high lowers `cs_n_o` at the same clock edge. Let H be `div_half_i`, with 0 treated as 1. `sclk_o` then stays high for H system cycles, and after that it toggles every H system cycles.
- R3: The block samples `sdata_i` at the system edge where `sclk_o` rises. The k-th rising serial-clock edge of a frame captures frame bit k.
- R4: `data_o` holds frame bits 3 to 14, with bit 3 as the most significant. `valid_o` is high for exactly the one system cycle in which `sclk_o` has just risen for the 14th time in the frame.
- R5: With `long_mode_i` = 0 at launch, a frame has exactly 14 rising serial-clock edges. `cs_n_o` returns to 1 at the same edge as the 14th rise.
- R6: With `long_mode_i` = 1 at launch, a frame has exactly 16 rising serial-clock edges. Bits 15 and 16 do not change `data_o`.
- R7: `err_o` pulses for one cycle, at the edge where `cs_n_o` returns high, when frame bit 1 or 2 is 1. In a long frame it also pulses when bit 15 or 16 is 1. Otherwise it stays low.
- R8: Between two frames, `cs_n_o` stays high for at least `quiet_i`+1 system cycles. When a start is already pending, it stays high for exactly that many cycles.
- R9: A start request during a frame or a quiet interval is held and launches exactly one further frame. Several such requests before that launch merge into one.
- R10: The mode and the divider are captured at launch. Changing `long_mode_i` or `div_half_i` during a frame has no effect on that frame.
- R11: `sclk_o` is 1 whenever `cs_n_o` is 1.
- R12: `valid_o` and `err_o` are never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion frame |
| long_mode_i | input | 1 | 1 selects the 16-clock frame, 0 selects the 14-clock frame |
| div_half_i | input | DIV_W | Serial clock half period in system cycles (0 acts as 1) |
| quiet_i | input | QUIET_W | Chip-select high time between frames, minus one, in system cycles |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip-select |
| sclk_o | output | 1 | Serial clock, idles high |
| data_o | output | RES_W | Latest 12-bit result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| err_o | output | 1 | One-cycle strobe for a pad bit that is not zero |

## Verification
The bench builds the block with a 4-bit divider field and a 5-bit quiet field. The result and pad widths keep their default values.

The narrow fields make the largest half period (15) and a zero setting (treated as 1) cheap to reach. A short frame at the largest divider fits within a few hundred cycles. The quiet settings used are small enough that back-to-back frames and held start requests can be measured to the exact cycle against the `quiet_i`+1 gap.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_QUIET = 2'd2
   } frame_state_e;

   function automatic int frame_bits(input int lead, input int res, input int trail,
                                     input bit long_frame);
      return lead + res + (long_frame ? trail : 0);
   endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] half_i,
   output logic             sclk_o,
   output logic             rise_o
);

   logic [DIV_W-1:0] hcnt;
   logic [DIV_W-1:0] limit;
   logic             sclk_q;
   logic             tick;

   assign limit  = (half_i == '0) ? DIV_W'(1) : half_i;
   assign tick   = run_i && (hcnt == limit - DIV_W'(1));
   assign rise_o = tick && !sclk_q;
   assign sclk_o = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt   <= '0;
         sclk_q <= 1'b1;
      end else if (!run_i) begin
         hcnt   <= '0;
         sclk_q <= 1'b1;
      end else if (tick) begin
         hcnt   <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         hcnt   <= hcnt + DIV_W'(1);
      end
   end

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
   import adc_frame_pkg::*;
#(
   parameter int DIV_W     = 8,
   parameter int QUIET_W   = 8,
   parameter int SHORT_LEN = 14,
   parameter int LONG_LEN  = 16,
   parameter int LEN_W     = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               long_i,
   input  logic [DIV_W-1:0]   half_i,
   input  logic [QUIET_W-1:0] quiet_i,
   input  logic               rise_i,
   output logic               run_o,
   output logic               cs_n_o,
   output logic               long_q_o,
   output logic [DIV_W-1:0]   half_q_o,
   output logic [LEN_W-1:0]   idx_o,
   output logic               last_o
);

   frame_state_e       st;
   logic               pend;
   logic [QUIET_W-1:0] qcnt;
   logic [LEN_W-1:0]   bcnt;
   logic               q_done;
   logic               want;
   logic               launch;
   logic [LEN_W-1:0]   len;

   assign want   = pend || start_i;
   assign q_done = (qcnt >= quiet_i);
   assign launch = want && ((st == ST_IDLE) || ((st == ST_QUIET) && q_done));
   assign len    = long_q_o ? LEN_W'(LONG_LEN) : LEN_W'(SHORT_LEN);
   assign last_o = rise_i && (bcnt == len - LEN_W'(1));
   assign run_o  = (st == ST_RUN);
   assign idx_o  = bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else begin
         pend <= want && !launch;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cs_n_o   <= 1'b1;
         qcnt     <= '0;
         bcnt     <= '0;
         long_q_o <= 1'b0;
         half_q_o <= '0;
      end else begin
         unique case (st)
            ST_IDLE, ST_QUIET: begin
               if (launch) begin
                  st       <= ST_RUN;
                  cs_n_o   <= 1'b0;
                  bcnt     <= '0;
                  long_q_o <= long_i;
                  half_q_o <= half_i;
               end else if (st == ST_QUIET) begin
                  if (q_done) st <= ST_IDLE;
                  else        qcnt <= qcnt + QUIET_W'(1);
               end
            end
            ST_RUN: begin
               if (rise_i) begin
                  bcnt <= bcnt + LEN_W'(1);
                  if (last_o) begin
                     st     <= ST_QUIET;
                     cs_n_o <= 1'b1;
                     qcnt   <= '0;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_capture.sv
module adc_capture #(
   parameter int RES_W      = 12,
   parameter int LEAD_BITS  = 2,
   parameter int TRAIL_BITS = 2,
   parameter int LEN_W      = 5,
   parameter bit CHECK_PAD  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_i,
   input  logic             bit_i,
   input  logic [LEN_W-1:0] idx_i,
   input  logic             last_i,
   input  logic             long_i,
   output logic [RES_W-1:0] data_o,
   output logic             valid_o,
   output logic             err_o
);

   localparam int HEAD_W   = LEAD_BITS + RES_W;
   localparam int DATA_IDX = HEAD_W - 1;

   logic [HEAD_W-2:0] sr;
   logic [HEAD_W-1:0] nxt;
   logic              at_data;

   assign nxt     = {sr, bit_i};
   assign at_data = sample_i && (idx_i == LEN_W'(DATA_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= at_data;
         if (sample_i) sr <= nxt[HEAD_W-2:0];
         if (at_data) data_o <= nxt[RES_W-1:0];
      end
   end

   if (CHECK_PAD) begin : g_pad_check
      logic lead_bad_q;
      logic lead_now;
      logic lead_src;
      logic trail_bad;

      assign lead_now  = |nxt[RES_W +: LEAD_BITS];
      assign lead_src  = at_data ? lead_now : lead_bad_q;
      assign trail_bad = long_i && (|nxt[TRAIL_BITS-1:0]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lead_bad_q <= 1'b0;
            err_o      <= 1'b0;
         end else begin
            if (at_data) lead_bad_q <= lead_now;
            err_o <= last_i && (lead_src || trail_bad);
         end
      end
   end else begin : g_no_pad_check
      assign err_o = 1'b0;
   end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
   import adc_frame_pkg::*;
#(
   parameter int RES_W      = 12,
   parameter int LEAD_BITS  = 2,
   parameter int TRAIL_BITS = 2,
   parameter int DIV_W      = 8,
   parameter int QUIET_W    = 8,
   parameter bit CHECK_PAD  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               long_mode_i,
   input  logic [DIV_W-1:0]   div_half_i,
   input  logic [QUIET_W-1:0] quiet_i,
   input  logic               sdata_i,
   output logic               cs_n_o,
   output logic               sclk_o,
   output logic [RES_W-1:0]   data_o,
   output logic               valid_o,
   output logic               err_o
);

   localparam int SHORT_LEN = frame_bits(LEAD_BITS, RES_W, TRAIL_BITS, 1'b0);
   localparam int LONG_LEN  = frame_bits(LEAD_BITS, RES_W, TRAIL_BITS, 1'b1);
   localparam int LEN_W     = $clog2(LONG_LEN + 1);

   if (RES_W < 2) begin : g_bad_res
      $error("RES_W must be at least 2");
   end
   if (LEAD_BITS < 1) begin : g_bad_lead
      $error("LEAD_BITS must be at least 1");
   end
   if (TRAIL_BITS < 1) begin : g_bad_trail
      $error("TRAIL_BITS must be at least 1");
   end
   if (DIV_W < 1 || QUIET_W < 1) begin : g_bad_cnt
      $error("DIV_W and QUIET_W must be at least 1");
   end

   logic             run;
   logic             rise;
   logic             last;
   logic             long_q;
   logic [DIV_W-1:0] half_q;
   logic [LEN_W-1:0] idx;

   adc_frame_ctrl #(
      .DIV_W    (DIV_W),
      .QUIET_W  (QUIET_W),
      .SHORT_LEN(SHORT_LEN),
      .LONG_LEN (LONG_LEN),
      .LEN_W    (LEN_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .long_i  (long_mode_i),
      .half_i  (div_half_i),
      .quiet_i (quiet_i),
      .rise_i  (rise),
      .run_o   (run),
      .cs_n_o  (cs_n_o),
      .long_q_o(long_q),
      .half_q_o(half_q),
      .idx_o   (idx),
      .last_o  (last)
   );

   adc_sclk_gen #(
      .DIV_W(DIV_W)
   ) u_sclk (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (run),
      .half_i(half_q),
      .sclk_o(sclk_o),
      .rise_o(rise)
   );

   adc_capture #(
      .RES_W     (RES_W),
      .LEAD_BITS (LEAD_BITS),
      .TRAIL_BITS(TRAIL_BITS),
      .LEN_W     (LEN_W),
      .CHECK_PAD (CHECK_PAD)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .sample_i(rise),
      .bit_i   (sdata_i),
      .idx_i   (idx),
      .last_i  (last),
      .long_i  (long_q),
      .data_o  (data_o),
      .valid_o (valid_o),
      .err_o   (err_o)
   );

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
   parameter int QUIET_W   = 8,
   parameter int SHORT_LEN = 14,
   parameter int LONG_LEN  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cs_n_o,
   input logic               sclk_o,
   input logic               valid_o,
   input logic               err_o,
   input logic [QUIET_W-1:0] quiet_i
);

   logic           p_cs;
   logic           p_sclk;
   logic           seen;
   logic [QUIET_W:0] hi_cnt;
   int             rcnt;
   logic           rose_now;
   int             rises_now;

   assign rose_now  = sclk_o && !p_sclk;
   assign rises_now = rcnt + (rose_now ? 1 : 0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_cs   <= 1'b1;
         p_sclk <= 1'b1;
         seen   <= 1'b0;
         hi_cnt <= '0;
         rcnt   <= 0;
      end else begin
         p_cs   <= cs_n_o;
         p_sclk <= sclk_o;
         if (!cs_n_o) seen <= 1'b1;
         if (!cs_n_o)         hi_cnt <= '0;
         else if (~&hi_cnt)   hi_cnt <= hi_cnt + 1'b1;
         if (p_cs && !cs_n_o) rcnt <= 0;
         else if (rose_now)   rcnt <= rcnt + 1;
      end
   end

   // R11: serial clock parked high while deselected
   assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sclk_o);

   // R12: strobes last one cycle
   assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   assert_err_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);

   // R8: chip-select high time between frames
   assert_quiet_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && p_cs && !cs_n_o) |-> (hi_cnt > {1'b0, quiet_i}));

   // R5 / R6: frame ends after 14 or 16 rising edges
   assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_cs && cs_n_o) |-> (rises_now == SHORT_LEN || rises_now == LONG_LEN));

   // R4: result strobe coincides with the 14th rise
   assert_valid_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (rose_now && rises_now == SHORT_LEN));

endmodule

bind adc_frame_reader adc_frame_reader_chk #(
   .QUIET_W  (QUIET_W),
   .SHORT_LEN(LEAD_BITS + RES_W),
   .LONG_LEN (LEAD_BITS + RES_W + TRAIL_BITS)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_n_o (cs_n_o),
   .sclk_o (sclk_o),
   .valid_o(valid_o),
   .err_o  (err_o),
   .quiet_i(quiet_i)
);

// File: tb/adc_frame_reader_tb.sv
`timescale 1ns/1ps
module adc_frame_reader_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        long_mode = 1'b0;
   logic [3:0]  div_half = 4'd2;
   logic [4:0]  quiet = 5'd3;
   logic        sdata = 1'b0;
   logic        cs_n, sclk, valid, err;
   logic [11:0] data;

   always #2.5 clk = ~clk;

   adc_frame_reader #(
      .RES_W(12), .LEAD_BITS(2), .TRAIL_BITS(2),
      .DIV_W(4), .QUIET_W(5), .CHECK_PAD(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .long_mode_i(long_mode),
      .div_half_i(div_half), .quiet_i(quiet), .sdata_i(sdata),
      .cs_n_o(cs_n), .sclk_o(sclk), .data_o(data), .valid_o(valid), .err_o(err)
   );

   int total = 0;
   int bad = 0;
   logic [15:0] pat = '0;

   int cyc = 0, cs_fall_cyc = 0, first_fall = -1, rises = 0;
   int rr_min = 1000, rr_max = 0, last_rise = -1;
   int v_cnt = 0, e_cnt = 0, v_wide = 0, rise_at_valid = 0;
   int frames_done = 0, hi_cnt = 0, last_gap = 0, idx = 0;
   logic [11:0] v_data = '0;
   logic p_cs = 1'b1, p_sclk = 1'b1, p_valid = 1'b0;

   // observer plus converter model: bit k is driven after the k-th falling edge
   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         p_cs = 1'b1; p_sclk = 1'b1; p_valid = 1'b0; idx = 0; sdata = 1'b0;
      end else begin
         if (p_cs && !cs_n) begin
            cs_fall_cyc = cyc; first_fall = -1; rises = 0;
            rr_min = 1000; rr_max = 0; last_rise = -1; last_gap = hi_cnt;
         end
         if (!cs_n && p_sclk && !sclk && first_fall < 0) first_fall = cyc - cs_fall_cyc;
         if (!p_cs && !p_sclk && sclk) begin
            rises++;
            if (last_rise >= 0) begin
               if (cyc - last_rise < rr_min) rr_min = cyc - last_rise;
               if (cyc - last_rise > rr_max) rr_max = cyc - last_rise;
            end
            last_rise = cyc;
         end
         if (valid) begin
            v_cnt++; v_data = data; rise_at_valid = rises;
            if (p_valid) v_wide++;
         end
         if (err) e_cnt++;
         if (!p_cs && cs_n) frames_done++;
         if (cs_n) hi_cnt++; else hi_cnt = 0;
         if (cs_n) idx = 0;
         else if (p_sclk && !sclk) idx++;
         sdata = (idx >= 1 && idx <= 16) ? pat[16-idx] : 1'b0;
         p_cs = cs_n; p_sclk = sclk; p_valid = valid;
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic wait_frames(input int n);
      while (frames_done < n) @(negedge clk);
      repeat (3) @(negedge clk);
      #1;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      check("R1", "cs_n after reset", cs_n, 1);
      check("R1", "sclk after reset", sclk, 1);
      check("R1", "valid after reset", valid, 0);
      check("R1", "err after reset", err, 0);
      check("R1", "data after reset", data, 0);
   endtask

   task automatic t_frame(input string tag, input bit lm, input int h,
                          input logic [1:0] ld, input logic [11:0] d,
                          input logic [1:0] tr, input int exp_err);
      int v0, e0, f0, heff;
      heff = (h == 0) ? 1 : h;
      pat = {ld, d, tr}; long_mode = lm; div_half = 4'(h);
      v0 = v_cnt; e0 = e_cnt; f0 = frames_done;
      pulse_start();
      #1;
      check("R2", {tag, " cs_n low one edge after start"}, cs_n, 0);
      wait_frames(f0 + 1);
      check(lm ? "R6" : "R5", {tag, " rising edges"}, rises, lm ? 16 : 14);
      check("R4", {tag, " valid count"}, v_cnt - v0, 1);
      check("R3", {tag, " captured data"}, v_data, d);
      check("R4", {tag, " valid at 14th rise"}, rise_at_valid, 14);
      check("R7", {tag, " error pulses"}, e_cnt - e0, exp_err);
      check("R2", {tag, " first half period"}, first_fall, heff);
      check("R2", {tag, " min period"}, rr_min, 2 * heff);
      check("R2", {tag, " max period"}, rr_max, 2 * heff);
      check("R12", {tag, " valid width"}, v_wide, 0);
      check("R11", {tag, " sclk idle high"}, sclk, 1);
   endtask

   task automatic t_pending();
      int f0;
      quiet = 5'd5; long_mode = 1'b0; div_half = 4'd2;
      pat = {2'b00, 12'h5A3, 2'b00};
      f0 = frames_done;
      pulse_start();
      repeat (10) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_frames(f0 + 2);
      check("R8", "gap with pending start", last_gap, 6);
      repeat (200) @(negedge clk);
      #1;
      check("R9", "merged requests give one extra frame", frames_done - f0, 2);
      f0 = frames_done;
      pulse_start();
      wait_frames(f0 + 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_frames(f0 + 2);
      check("R9", "start during quiet kept", frames_done - f0, 2);
      check("R8", "gap after start in quiet", last_gap, 6);
      check("R3", "data in back-to-back frame", v_data, 12'h5A3);
   endtask

   task automatic t_latch();
      int f0;
      long_mode = 1'b1; div_half = 4'd2;
      pat = {2'b00, 12'h0C3, 2'b00};
      f0 = frames_done;
      pulse_start();
      repeat (5) @(negedge clk);
      long_mode = 1'b0; div_half = 4'd7;
      wait_frames(f0 + 1);
      check("R10", "mode kept after mid-frame change", rises, 16);
      check("R10", "divider kept after mid-frame change", rr_max, 4);
      check("R10", "data after mid-frame change", v_data, 12'h0C3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL R2 watchdog: actual=hung expected=frames complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      quiet = 5'd3;
      t_frame("short", 1'b0, 2, 2'b00, 12'hA5C, 2'b00, 0);
      t_frame("long", 1'b1, 3, 2'b00, 12'h3F1, 2'b00, 0);
      t_frame("long trail set R6", 1'b1, 2, 2'b00, 12'h812, 2'b11, 1);
      t_frame("long one trail", 1'b1, 1, 2'b00, 12'h7FE, 2'b01, 1);
      t_frame("short lead set", 1'b0, 2, 2'b10, 12'h000, 2'b00, 1);
      t_frame("short trail ignored", 1'b0, 2, 2'b00, 12'h456, 2'b11, 0);
      t_frame("div zero", 1'b0, 0, 2'b00, 12'hFFF, 2'b00, 0);
      t_frame("div max", 1'b0, 15, 2'b01, 12'h001, 2'b00, 1);
      t_pending();
      t_latch();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule